// File: doc/BRIEF.md
# Three-Wide Instruction Dispatch Arbiter

This block sits between the bottom of a twelve-entry decoded-instruction buffer and three issue queues: floating-point, vector and general-purpose. Each cycle it looks at the three oldest buffer entries and decides, in program order, how many of them leave the buffer. It then steers each leaving instruction to the issue queue its class names and requests a completion-queue entry for it. Decoding, renaming, the issue-queue storage and the execution units are outside this block. The instruction class of each slot and the free-space counts of the four queues arrive as inputs.

Three limits shape every decision. Each issue queue takes a fixed number of instructions per cycle: one for floating-point, two for vector and three for general-purpose. Each issue queue must also have room, counting the entries already granted earlier in the same cycle. Every leaving instruction needs a completion-queue entry, and this includes the class that occupies no issue queue. The first slot that fails any check stops every younger slot. The grant count leaves as a two-bit value, so the buffer can shift by that many entries.

Each slot is judged combinationally into one of six named outcomes. SL_GO means the slot may leave. SL_HELD means flush is asserted or reset is active. SL_EMPTY means the slot holds no instruction. SL_CQ_FULL means there is no completion entry for it. SL_RATE_CAP means its issue queue has already reached its per-cycle limit. SL_IQ_FULL means its issue queue has no room. A slot dispatches when its outcome is SL_GO and every older slot also dispatches. There are no transitions between cycles: the outcome is recomputed from the inputs every cycle.

Top module: `dispatch_arbiter`

## Requirements
- R1: The grants always form an in-order prefix: `disp_vld` equals the lowest `disp_cnt` bits set. `disp_cnt` counts from 0 to 3, so no more than three instructions leave per cycle.
- R2: No more than one granted slot has class 2'b11 (floating-point) in one cycle.
- R3: No more than two granted slots have class 2'b10 (vector) in one cycle.
- R4: Up to three granted slots may have class 2'b01 (general-purpose) in one cycle.
- R5: The number of slots granted to an issue queue never exceeds that queue's free-space input.
- R6: The total number of grants never exceeds `cq_free`. This also holds for class 2'b00 (completion entry only, no issue queue).
- R7: If a slot is not granted, no younger slot is granted in that cycle.
- R8: While `flush` is high, no slot is granted and `disp_cnt` is 0.
- R9: For a granted slot, exactly the select that matches its class is set: `fp_sel` for 2'b11, `vec_sel` for 2'b10, `gp_sel` for 2'b01, and none for 2'b00. `cq_alloc` equals `disp_vld`. A slot that is not granted has all of its selects at 0.
- R10: A slot whose valid bit is 0 is not granted and stops the younger slots.
- R11: While `rst_n` is low, no slot is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the in-module temporal checks |
| rst_n | input | 1 | Active-low reset; blocks all grants while low |
| flush | input | 1 | Cancels every grant in the current cycle |
| slot_vld | input | 3 | Valid bit of buffer slots 0 (oldest) to 2 |
| slot_cls | input | 3x2 | Class per slot: 00 completion-only, 01 general, 10 vector, 11 floating |
| fp_free | input | 5 | Free entries in the floating-point issue queue |
| vec_free | input | 5 | Free entries in the vector issue queue |
| gp_free | input | 5 | Free entries in the general-purpose issue queue |
| cq_free | input | 5 | Free entries in the completion queue |
| disp_vld | output | 3 | Per-slot dispatch grant |
| cq_alloc | output | 3 | Per-slot completion-entry allocation request |
| fp_sel | output | 3 | Per-slot steer to the floating-point issue queue |
| vec_sel | output | 3 | Per-slot steer to the vector issue queue |
| gp_sel | output | 3 | Per-slot steer to the general-purpose issue queue |
| disp_cnt | output | 2 | Number of slots dispatched this cycle |

## Verification
Every output is a combinational function of the present inputs, so each result is due in the same cycle as the stimulus that causes it. No register sits between them. The bench changes inputs on the falling clock edge and samples all outputs 2 ns later, well before the next rising edge. Each sample is compared with a reference function that walks the slots in order. Directed cases cover each per-class limit, queue room, completion space, flush, reset and the in-order stop. Random cases mix all of these.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

    typedef enum logic [1:0] {
        CLS_CQ_ONLY = 2'd0,
        CLS_GEN     = 2'd1,
        CLS_VEC     = 2'd2,
        CLS_FLT     = 2'd3
    } iq_class_e;

    typedef enum logic [2:0] {
        SL_GO,
        SL_HELD,
        SL_EMPTY,
        SL_CQ_FULL,
        SL_RATE_CAP,
        SL_IQ_FULL
    } slot_state_e;

endpackage

// File: rtl/dsp_class_tally.sv
module dsp_class_tally
    import dsp_pkg::*;
#(
    parameter int SLOTS = 3,
    parameter int PW    = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0][1:0]    cls,
    output logic [SLOTS-1:0][PW-1:0] pr_fp,
    output logic [SLOTS-1:0][PW-1:0] pr_vec,
    output logic [SLOTS-1:0][PW-1:0] pr_gp
);

    // Count of each class among strictly older slots.
    logic [PW-1:0] run_fp, run_vec, run_gp;

    always_comb begin
        run_fp  = '0;
        run_vec = '0;
        run_gp  = '0;
        for (int i = 0; i < SLOTS; i++) begin
            pr_fp[i]  = run_fp;
            pr_vec[i] = run_vec;
            pr_gp[i]  = run_gp;
            if (iq_class_e'(cls[i]) == CLS_FLT) run_fp  = run_fp  + PW'(1);
            if (iq_class_e'(cls[i]) == CLS_VEC) run_vec = run_vec + PW'(1);
            if (iq_class_e'(cls[i]) == CLS_GEN) run_gp  = run_gp  + PW'(1);
        end
    end

endmodule

// File: rtl/dsp_slot_gate.sv
module dsp_slot_gate
    import dsp_pkg::*;
#(
    parameter int IDX     = 0,
    parameter int SLOTS   = 3,
    parameter int PW      = 2,
    parameter int SPW     = 5,
    parameter int CQW     = 5,
    parameter int FP_RATE = 1,
    parameter int VEC_RATE = 2,
    parameter int GP_RATE = 3
) (
    input  logic           hold,
    input  logic           vld,
    input  logic [1:0]     cls,
    input  logic [PW-1:0]  prior_fp,
    input  logic [PW-1:0]  prior_vec,
    input  logic [PW-1:0]  prior_gp,
    input  logic [SPW-1:0] fp_free,
    input  logic [SPW-1:0] vec_free,
    input  logic [SPW-1:0] gp_free,
    input  logic [CQW-1:0] cq_free,
    output logic           go
);

    slot_state_e st;
    int          rate;
    int          used;
    int          room;

    // Pick the limit set of the target issue queue.
    always_comb begin
        rate = SLOTS;
        used = 0;
        room = SLOTS;
        unique case (iq_class_e'(cls))
            CLS_FLT: begin
                rate = FP_RATE;
                used = int'(prior_fp);
                room = int'(fp_free);
            end
            CLS_VEC: begin
                rate = VEC_RATE;
                used = int'(prior_vec);
                room = int'(vec_free);
            end
            CLS_GEN: begin
                rate = GP_RATE;
                used = int'(prior_gp);
                room = int'(gp_free);
            end
            CLS_CQ_ONLY: begin
                rate = SLOTS;
                used = 0;
                room = SLOTS;
            end
        endcase
    end

    // Outcome of this slot; older slots are assumed granted (prefix applied above).
    always_comb begin
        if (hold)                     st = SL_HELD;
        else if (!vld)                st = SL_EMPTY;
        else if (int'(cq_free) <= IDX) st = SL_CQ_FULL;
        else if (used >= rate)        st = SL_RATE_CAP;
        else if (used >= room)        st = SL_IQ_FULL;
        else                          st = SL_GO;
    end

    assign go = (st == SL_GO);

endmodule

// File: rtl/dsp_grant_count.sv
module dsp_grant_count #(
    parameter int SLOTS = 3,
    parameter int CW    = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0] grant,
    output logic [CW-1:0]    cnt
);

    always_comb begin
        cnt = '0;
        for (int i = 0; i < SLOTS; i++) begin
            cnt = cnt + CW'(grant[i]);
        end
    end

endmodule

// File: rtl/dispatch_arbiter.sv
module dispatch_arbiter
    import dsp_pkg::*;
#(
    parameter int SLOTS    = 3,
    parameter int SPW      = 5,
    parameter int CQW      = 5,
    parameter int FP_RATE  = 1,
    parameter int VEC_RATE = 2,
    parameter int GP_RATE  = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush,
    input  logic [SLOTS-1:0]                 slot_vld,
    input  logic [SLOTS-1:0][1:0]            slot_cls,
    input  logic [SPW-1:0]                   fp_free,
    input  logic [SPW-1:0]                   vec_free,
    input  logic [SPW-1:0]                   gp_free,
    input  logic [CQW-1:0]                   cq_free,
    output logic [SLOTS-1:0]                 disp_vld,
    output logic [SLOTS-1:0]                 cq_alloc,
    output logic [SLOTS-1:0]                 fp_sel,
    output logic [SLOTS-1:0]                 vec_sel,
    output logic [SLOTS-1:0]                 gp_sel,
    output logic [$clog2(SLOTS+1)-1:0]       disp_cnt
);

    localparam int PW = $clog2(SLOTS + 1);

    logic                    hold;
    logic [SLOTS-1:0]        go;
    logic [SLOTS-1:0]        grant;
    logic [SLOTS-1:0][PW-1:0] pr_fp, pr_vec, pr_gp;

    assign hold = flush | ~rst_n;

    dsp_class_tally #(.SLOTS(SLOTS), .PW(PW)) u_tally (
        .cls    (slot_cls),
        .pr_fp  (pr_fp),
        .pr_vec (pr_vec),
        .pr_gp  (pr_gp)
    );

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        dsp_slot_gate #(
            .IDX(i), .SLOTS(SLOTS), .PW(PW), .SPW(SPW), .CQW(CQW),
            .FP_RATE(FP_RATE), .VEC_RATE(VEC_RATE), .GP_RATE(GP_RATE)
        ) u_gate (
            .hold      (hold),
            .vld       (slot_vld[i]),
            .cls       (slot_cls[i]),
            .prior_fp  (pr_fp[i]),
            .prior_vec (pr_vec[i]),
            .prior_gp  (pr_gp[i]),
            .fp_free   (fp_free),
            .vec_free  (vec_free),
            .gp_free   (gp_free),
            .cq_free   (cq_free),
            .go        (go[i])
        );

        // In-order chain: a slot leaves only behind a leaving elder.
        if (i == 0) begin : g_head
            assign grant[i] = go[i];
        end else begin : g_tail
            assign grant[i] = go[i] & grant[i-1];
        end

        assign fp_sel[i]  = grant[i] & (iq_class_e'(slot_cls[i]) == CLS_FLT);
        assign vec_sel[i] = grant[i] & (iq_class_e'(slot_cls[i]) == CLS_VEC);
        assign gp_sel[i]  = grant[i] & (iq_class_e'(slot_cls[i]) == CLS_GEN);

        AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0({fp_sel[i], vec_sel[i], gp_sel[i]})); // R9
    end

    assign disp_vld = grant;
    assign cq_alloc = grant;

    dsp_grant_count #(.SLOTS(SLOTS), .CW(PW)) u_count (
        .grant (grant),
        .cnt   (disp_cnt)
    );

    AST_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        int'(disp_vld) == ((1 << disp_cnt) - 1)); // R1
    AST_FP_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fp_sel) <= FP_RATE); // R2
    AST_VEC_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vec_sel) <= VEC_RATE); // R3
    AST_FP_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fp_sel) <= int'(fp_free)); // R5
    AST_VEC_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vec_sel) <= int'(vec_free)); // R5
    AST_GP_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gp_sel) <= int'(gp_free)); // R5
    AST_CQ_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(disp_cnt) <= int'(cq_free)); // R6
    AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (disp_cnt == '0)); // R8

endmodule

// File: tb/tb_dispatch_arbiter.sv
module tb_dispatch_arbiter;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             flush;
    logic [2:0]       slot_vld;
    logic [2:0][1:0]  slot_cls;
    logic [4:0]       fp_free, vec_free, gp_free, cq_free;
    logic [2:0]       disp_vld, cq_alloc, fp_sel, vec_sel, gp_sel;
    logic [1:0]       disp_cnt;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dispatch_arbiter dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .slot_vld(slot_vld), .slot_cls(slot_cls),
        .fp_free(fp_free), .vec_free(vec_free), .gp_free(gp_free), .cq_free(cq_free),
        .disp_vld(disp_vld), .cq_alloc(cq_alloc),
        .fp_sel(fp_sel), .vec_sel(vec_sel), .gp_sel(gp_sel),
        .disp_cnt(disp_cnt)
    );

    // Reference: walk slots oldest first, stop at the first that cannot leave.
    function automatic logic [16:0] model(input logic rn, input logic fl,
                                          input logic [2:0] v, input logic [2:0][1:0] c,
                                          input logic [4:0] ff, input logic [4:0] vf,
                                          input logic [4:0] gf, input logic [4:0] qf);
        int nf = 0, nv = 0, ng = 0, n = 0;
        logic [2:0] g = '0, sf = '0, sv = '0, sg = '0;
        bit stop = 0;
        for (int i = 0; i < 3; i++) begin
            bit ok;
            ok = !stop && rn && !fl && v[i] && (n < int'(qf));
            case (c[i])
                2'b11: ok = ok && nf < 1 && nf < int'(ff);
                2'b10: ok = ok && nv < 2 && nv < int'(vf);
                2'b01: ok = ok && ng < 3 && ng < int'(gf);
                default: ;
            endcase
            if (ok) begin
                g[i] = 1'b1; n++;
                if (c[i] == 2'b11) begin sf[i] = 1'b1; nf++; end
                if (c[i] == 2'b10) begin sv[i] = 1'b1; nv++; end
                if (c[i] == 2'b01) begin sg[i] = 1'b1; ng++; end
            end else stop = 1;
        end
        return {2'(n), g, g, sf, sv, sg};
    endfunction

    task automatic check(input string tag);
        logic [16:0] got, exp;
        got = {disp_cnt, disp_vld, cq_alloc, fp_sel, vec_sel, gp_sel};
        exp = model(rst_n, flush, slot_vld, slot_cls, fp_free, vec_free, gp_free, cq_free);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic fl, input logic [2:0] v,
                         input logic [1:0] c2, input logic [1:0] c1, input logic [1:0] c0,
                         input int ff, input int vf, input int gf, input int qf,
                         input string tag);
        @(negedge clk);
        flush = fl; slot_vld = v; slot_cls = {c2, c1, c0};
        fp_free = 5'(ff); vec_free = 5'(vf); gp_free = 5'(gf); cq_free = 5'(qf);
        #2 check(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        rst_n = 1'b0; flush = 1'b0; slot_vld = '0; slot_cls = '0;
        fp_free = '0; vec_free = '0; gp_free = '0; cq_free = '0;
        // R11: reset blocks grants even with all room available
        apply(1'b0, 3'b111, 2'b01, 2'b01, 2'b01, 8, 8, 8, 8, "R11 reset");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        apply(1'b0, 3'b000, 2'b01, 2'b01, 2'b01, 8, 8, 8, 8, "R10 idle");
        apply(1'b0, 3'b111, 2'b11, 2'b11, 2'b11, 8, 8, 8, 8, "R2 fp one");
        apply(1'b0, 3'b111, 2'b10, 2'b10, 2'b10, 8, 8, 8, 8, "R3 vec two");
        apply(1'b0, 3'b111, 2'b01, 2'b01, 2'b01, 8, 8, 8, 8, "R4 gp three");
        apply(1'b0, 3'b111, 2'b01, 2'b01, 2'b01, 8, 8, 2, 8, "R5 gp room");
        apply(1'b0, 3'b111, 2'b01, 2'b10, 2'b10, 8, 1, 8, 8, "R5 vec room");
        apply(1'b0, 3'b111, 2'b00, 2'b00, 2'b00, 8, 8, 8, 0, "R6 cq empty");
        apply(1'b0, 3'b111, 2'b00, 2'b00, 2'b00, 0, 0, 0, 2, "R6 cq two");
        apply(1'b0, 3'b111, 2'b01, 2'b11, 2'b11, 8, 8, 8, 8, "R7 order");
        apply(1'b0, 3'b110, 2'b01, 2'b01, 2'b01, 8, 8, 8, 8, "R10 hole");
        apply(1'b1, 3'b111, 2'b01, 2'b10, 2'b11, 8, 8, 8, 8, "R8 flush");
        apply(1'b0, 3'b111, 2'b00, 2'b10, 2'b11, 8, 8, 8, 8, "R9 selects");
        apply(1'b0, 3'b111, 2'b01, 2'b01, 2'b11, 0, 8, 8, 8, "R5 fp full");
        for (int k = 0; k < 3000; k++) begin
            apply(($urandom % 16) == 0, 3'($urandom), 2'($urandom), 2'($urandom),
                  2'($urandom), $urandom % 4, $urandom % 4, $urandom % 5,
                  $urandom % 5, "R1 R7 random");
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule